// File: doc/BRIEF.md
# Chained Event Counter Bank

The block is a bank of performance event counters. It holds a parameterised number of general counters (up to 31, indices 0 to NUM_CTR-1) and one free-running cycle counter at index 31. All counters are 64 bits wide. Each general counter has an event-type register. A general counter advances when an incoming event pulse carries the number held in its type register. It also advances when software writes the increment register with the counter's bit set and the counter is typed for software increments.

Adjacent even/odd counters can be joined into one wider counter. When an even counter overflows, the odd counter above it receives one chain event. A level interrupt goes high while any counter that is enabled and has its interrupt enabled has an overflow flag set. Registers are written and read through a single-cycle write strobe and a combinational read port.

Register map (7-bit address): control 0x00; counter-enable set/clear 0x01/0x02; interrupt-enable set/clear 0x03/0x04; overflow-flag set/clear 0x05/0x06; software increment 0x07; counter i at 0x20+i (cycle counter at 0x3F); type of counter i at 0x40+i. Control bits: [0] global enable, [1] clear all general counters, [2] clear cycle counter, [4] 64-bit overflow for the cycle counter, [5] 64-bit overflow for general counters, [12:8] read-only counter count.

Top module: `evt_ctr_bank`

## Requirements
- R1: No counter moves unless control bit 0 is set and the counter's bit is set in the counter-enable bitmap.
- R2: A general counter advances by one on an event pulse whose number, masked to 10 bits (16 bits when EXT_EVT is set), equals its type. Type writes are stored masked to the same width.
- R3: A write to address 0x07 advances every enabled general counter whose bit is set in the written value and whose type is 0x000. Counters with another type, counters whose bit is clear, and the cycle counter are left unchanged.
- R4: When a software increment and a matching event pulse reach the same counter in one cycle, the counter advances by two.
- R5: A general counter overflows when its low 32 bits wrap past zero, provided control bit 5 is clear. The overflow sets the counter's bit in the overflow-flag bitmap.
- R6: With control bit 5 set, general-counter overflow is taken only on a wrap of all 64 bits.
- R7: With control bit 5 clear, an overflow of even counter i gives counter i+1 one increment with event number 0x01E, when i+1 is implemented. That increment can itself overflow and set bit i+1.
- R8: With control bit 5 set, no chain increment is passed to the odd counter.
- R9: The cycle counter advances once per clock while enabled (bit 31 of the enable bitmap). It overflows on a 32-bit wrap, or on a 64-bit wrap when control bit 4 is set, and sets flag bit 31.
- R10: Writing control bit 1 clears all general counters. Writing control bit 2 clears the cycle counter. Both bits read back as zero.
- R11: irq_o is high exactly when control bit 0 is set and overflow flags AND counter enables AND interrupt enables is nonzero.
- R12: Control bits [12:8] read NUM_CTR. The set registers only affect bits [NUM_CTR-1:0] and bit 31. The clear registers remove the bits written as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 7 | Write address |
| wr_data_i | input | 64 | Write data |
| rd_addr_i | input | 7 | Read address |
| rd_data_o | output | 64 | Read data, combinational |
| evt_valid_i | input | 1 | Event pulse valid |
| evt_num_i | input | 16 | Event number of the pulse |
| irq_o | output | 1 | Overflow interrupt level |

## Verification
Two increment sources can reach the same counter in one cycle: a software-increment write and a hardware event pulse. The bench drives both in a single clock for a counter typed 0x000 and expects the value to rise by exactly two. The second same-cycle case is an even counter's overflow and the chain increment it passes upward. This is provoked by presetting both halves of a pair to 0xFFFFFFFF and sending one event; both overflow flags and both new values are then checked. The same stimulus is repeated with the 64-bit mode set, where the odd counter must stay still.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  localparam int ADDR_W = 7;
  localparam int CYC_IDX = 31;

  localparam logic [ADDR_W-1:0] A_CTRL     = 7'h00;
  localparam logic [ADDR_W-1:0] A_CEN_SET  = 7'h01;
  localparam logic [ADDR_W-1:0] A_CEN_CLR  = 7'h02;
  localparam logic [ADDR_W-1:0] A_IEN_SET  = 7'h03;
  localparam logic [ADDR_W-1:0] A_IEN_CLR  = 7'h04;
  localparam logic [ADDR_W-1:0] A_OVS_SET  = 7'h05;
  localparam logic [ADDR_W-1:0] A_OVS_CLR  = 7'h06;
  localparam logic [ADDR_W-1:0] A_SWINC    = 7'h07;
  localparam logic [ADDR_W-1:0] A_CNT_BASE = 7'h20;
  localparam logic [ADDR_W-1:0] A_CYC      = 7'h3F;
  localparam logic [ADDR_W-1:0] A_TYP_BASE = 7'h40;

  localparam int B_EN  = 0;
  localparam int B_CLG = 1;
  localparam int B_CLC = 2;
  localparam int B_LC  = 4;
  localparam int B_LG  = 5;

  localparam logic [15:0] EVT_SWINC = 16'h0000;
  localparam logic [15:0] EVT_CHAIN = 16'h001E;
endpackage

// File: rtl/ecb_counter.sv
module ecb_counter (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  inc_i,
  input  logic        clr_i,
  input  logic        wr_i,
  input  logic [63:0] wr_data_i,
  input  logic        long_i,
  output logic [63:0] cnt_o,
  output logic        ovf_o
);
  logic [63:0] cnt_q;
  logic [64:0] sum;
  logic [32:0] lo;

  assign sum = {1'b0, cnt_q} + 65'(inc_i);
  assign lo  = {1'b0, cnt_q[31:0]} + 33'(inc_i);
  // carry out of the selected width marks a wrap past zero
  assign ovf_o = !(clr_i || wr_i) && (long_i ? sum[64] : lo[32]);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (wr_i)  cnt_q <= wr_data_i;
    else            cnt_q <= sum[63:0];
  end
endmodule

// File: rtl/ecb_ctrl.sv
module ecb_ctrl
  import ecb_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter bit LONG_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [31:0]       ovf_i,
  output logic              ctl_en_o,
  output logic              long_cyc_o,
  output logic              long_gen_o,
  output logic [31:0]       cnten_o,
  output logic [31:0]       inten_o,
  output logic [31:0]       ovs_o,
  output logic              irq_o
);
  localparam logic [31:0] VALID = 32'((64'd1 << NUM_CTR) - 64'd1) | 32'h8000_0000;

  logic        en_q, lc_q, lg_q;
  logic [31:0] cen_q, ien_q, ovs_q;
  logic [31:0] cen_n, ien_n, ovs_n;

  function automatic logic [31:0] upd(input logic [31:0] cur, input logic set, input logic clr,
                                      input logic [31:0] d);
    logic [31:0] r;
    r = cur;
    if (clr) r = r & ~d;
    if (set) r = r | (d & VALID);
    return r;
  endfunction

  always_comb begin
    cen_n = upd(cen_q, wr_en_i && wr_addr_i == A_CEN_SET, wr_en_i && wr_addr_i == A_CEN_CLR, wr_data_i);
    ien_n = upd(ien_q, wr_en_i && wr_addr_i == A_IEN_SET, wr_en_i && wr_addr_i == A_IEN_CLR, wr_data_i);
    // a fresh overflow survives a same-cycle clear
    ovs_n = upd(ovs_q, wr_en_i && wr_addr_i == A_OVS_SET, wr_en_i && wr_addr_i == A_OVS_CLR, wr_data_i)
            | (ovf_i & VALID);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; lc_q <= 1'b0; lg_q <= 1'b0;
      cen_q <= '0; ien_q <= '0; ovs_q <= '0;
    end else begin
      if (wr_en_i && wr_addr_i == A_CTRL) begin
        en_q <= wr_data_i[B_EN];
        lc_q <= wr_data_i[B_LC];
        lg_q <= LONG_EN ? wr_data_i[B_LG] : 1'b0;
      end
      cen_q <= cen_n;
      ien_q <= ien_n;
      ovs_q <= ovs_n;
    end
  end

  assign ctl_en_o   = en_q;
  assign long_cyc_o = lc_q;
  assign long_gen_o = lg_q;
  assign cnten_o    = cen_q;
  assign inten_o    = ien_q;
  assign ovs_o      = ovs_q;
  assign irq_o      = en_q && |(ovs_q & cen_q & ien_q);
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
  import ecb_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter bit LONG_EN = 1'b1,
  parameter bit EXT_EVT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [63:0]       wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [63:0]       rd_data_o,
  input  logic              evt_valid_i,
  input  logic [15:0]       evt_num_i,
  output logic              irq_o
);
  localparam logic [15:0] EVT_MASK = EXT_EVT ? 16'hFFFF : 16'h03FF;

  logic        ctl_en, long_cyc, long_gen;
  logic [31:0] cnten, inten, ovs, ovf_vec;
  logic [NUM_CTR-1:0][63:0] gcnt;
  logic [NUM_CTR-1:0]       gen_ovf, chain_out;
  logic [15:0] etype_q [NUM_CTR];
  logic [63:0] ccnt;
  logic        cyc_ovf;
  logic        sel_swinc, clr_gen, clr_cyc;

  assign sel_swinc = wr_en_i && wr_addr_i == A_SWINC;
  assign clr_gen   = wr_en_i && wr_addr_i == A_CTRL && wr_data_i[B_CLG];
  assign clr_cyc   = wr_en_i && wr_addr_i == A_CTRL && wr_data_i[B_CLC];

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    localparam logic [ADDR_W-1:0] CNT_A = A_CNT_BASE + 7'(i);
    localparam logic [ADDR_W-1:0] TYP_A = A_TYP_BASE + 7'(i);
    logic act, hw_hit, sw_hit, ch_hit;

    assign act    = ctl_en && cnten[i];
    assign hw_hit = act && evt_valid_i && ((evt_num_i & EVT_MASK) == etype_q[i]);
    assign sw_hit = act && sel_swinc && wr_data_i[i] && (etype_q[i] == EVT_SWINC);

    if (i % 2 == 1) begin : g_odd
      assign ch_hit       = act && chain_out[i-1] && (etype_q[i] == EVT_CHAIN);
      assign chain_out[i] = 1'b0;
    end else if (i + 1 < NUM_CTR) begin : g_even_pair
      assign ch_hit       = 1'b0;
      assign chain_out[i] = gen_ovf[i] && !long_gen;
    end else begin : g_even_last
      assign ch_hit       = 1'b0;
      assign chain_out[i] = 1'b0;
    end

    ecb_counter u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inc_i     (2'(hw_hit) + 2'(sw_hit) + 2'(ch_hit)),
      .clr_i     (clr_gen),
      .wr_i      (wr_en_i && wr_addr_i == CNT_A),
      .wr_data_i (wr_data_i),
      .long_i    (long_gen),
      .cnt_o     (gcnt[i]),
      .ovf_o     (gen_ovf[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              etype_q[i] <= EVT_SWINC;
      else if (wr_en_i && wr_addr_i == TYP_A)   etype_q[i] <= wr_data_i[15:0] & EVT_MASK;
    end
  end

  ecb_counter u_cyc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     ({1'b0, ctl_en && cnten[CYC_IDX]}),
    .clr_i     (clr_cyc),
    .wr_i      (wr_en_i && wr_addr_i == A_CYC),
    .wr_data_i (wr_data_i),
    .long_i    (long_cyc),
    .cnt_o     (ccnt),
    .ovf_o     (cyc_ovf)
  );

  always_comb begin
    ovf_vec = '0;
    ovf_vec[NUM_CTR-1:0] = gen_ovf;
    ovf_vec[CYC_IDX] = cyc_ovf;
  end

  ecb_ctrl #(.NUM_CTR(NUM_CTR), .LONG_EN(LONG_EN)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i[31:0]),
    .ovf_i      (ovf_vec),
    .ctl_en_o   (ctl_en),
    .long_cyc_o (long_cyc),
    .long_gen_o (long_gen),
    .cnten_o    (cnten),
    .inten_o    (inten),
    .ovs_o      (ovs),
    .irq_o      (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_CTRL: begin
        rd_data_o[B_EN]  = ctl_en;
        rd_data_o[B_LC]  = long_cyc;
        rd_data_o[B_LG]  = long_gen;
        rd_data_o[12:8]  = 5'(NUM_CTR);
      end
      A_CEN_SET, A_CEN_CLR: rd_data_o = {32'b0, cnten};
      A_IEN_SET, A_IEN_CLR: rd_data_o = {32'b0, inten};
      A_OVS_SET, A_OVS_CLR: rd_data_o = {32'b0, ovs};
      A_CYC:                rd_data_o = ccnt;
      default: ;
    endcase
    for (int i = 0; i < NUM_CTR; i++) begin
      if (rd_addr_i == A_CNT_BASE + 7'(i)) rd_data_o = gcnt[i];
      if (rd_addr_i == A_TYP_BASE + 7'(i)) rd_data_o = {48'b0, etype_q[i]};
    end
  end
endmodule

// File: rtl/ecb_chk.sv
module ecb_chk
  import ecb_pkg::*;
#(
  parameter int NUM_CTR = 4
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     wr_en_i,
  input logic [ADDR_W-1:0]        rd_addr_i,
  input logic [63:0]              rd_data_o,
  input logic                     irq_o,
  input logic                     ctl_en,
  input logic [31:0]              ovs,
  input logic [NUM_CTR*64-1:0]    gcnt,
  input logic [63:0]              ccnt
);
  localparam logic [31:0] VALID = 32'((64'd1 << NUM_CTR) - 64'd1) | 32'h8000_0000;

  // R1
  idle_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_en && !wr_en_i) |=> ($stable(gcnt) && $stable(ccnt)));

  // R5
  ovs_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((ovs & $past(ovs)) == $past(ovs)));

  // R10
  oneshot_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == A_CTRL) |-> (rd_data_o[B_CLC:B_CLG] == 2'b00));

  // R11
  irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctl_en);

  // R12
  cen_valid_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == A_CEN_SET) |-> ((rd_data_o[31:0] & ~VALID) == 32'b0));
endmodule

bind evt_ctr_bank ecb_chk #(.NUM_CTR(NUM_CTR)) u_ecb_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o),
  .ctl_en    (ctl_en),
  .ovs       (ovs),
  .gcnt      (gcnt),
  .ccnt      (ccnt)
);

// File: tb/tb_evt_ctr_bank.sv
`timescale 1ns/1ps
module tb_evt_ctr_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [6:0]  wr_addr_i = '0;
  logic [63:0] wr_data_i = '0;
  logic [6:0]  rd_addr_i = '0;
  logic [63:0] rd_data_o;
  logic        evt_valid_i = 1'b0;
  logic [15:0] evt_num_i = '0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  localparam logic [6:0] CTRL = 7'h00, CSET = 7'h01, CCLR = 7'h02, ISET = 7'h03,
                         OSET = 7'h05, OCLR = 7'h06, SWI = 7'h07, CYC = 7'h3F;

  always #10 clk_i = ~clk_i;

  evt_ctr_bank dut (.*);

  function automatic logic [6:0] cnt_a(input int i); return 7'h20 + 7'(i); endfunction
  function automatic logic [6:0] typ_a(input int i); return 7'h40 + 7'(i); endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [63:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic ev(input logic [15:0] n);
    evt_valid_i = 1'b1; evt_num_i = n;
    @(negedge clk_i);
    evt_valid_i = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [63:0] d);
    rd_addr_i = a; #1; d = rd_data_o;
  endtask

  task automatic t_reset;
    logic [63:0] v;
    rd(CTRL, v); chk("R12 reset ctrl", v, 64'h400);
    rd(cnt_a(0), v); chk("R1 reset cnt0", v, 64'h0);
    chk("R11 reset irq", 64'(irq_o), 64'h0);
  endtask

  task automatic t_gate;
    logic [63:0] v;
    wr(typ_a(0), 64'h23); wr(CSET, 64'h1);
    ev(16'h23); rd(cnt_a(0), v); chk("R1 global off", v, 64'h0);
    wr(CTRL, 64'h1); wr(CCLR, 64'h1);
    ev(16'h23); rd(cnt_a(0), v); chk("R1 counter off", v, 64'h0);
    wr(CSET, 64'h1);
    ev(16'h23); rd(cnt_a(0), v); chk("R1 both on", v, 64'h1);
  endtask

  task automatic t_match;
    logic [63:0] v;
    wr(typ_a(1), 64'h411); rd(typ_a(1), v); chk("R2 type masked", v, 64'h011);
    wr(CSET, 64'h2);
    ev(16'h411); rd(cnt_a(1), v); chk("R2 masked match", v, 64'h1);
    ev(16'h012); rd(cnt_a(1), v); chk("R2 other event", v, 64'h1);
    ev(16'h011); rd(cnt_a(1), v); chk("R2 exact match", v, 64'h2);
  endtask

  task automatic t_swinc;
    logic [63:0] v;
    wr(typ_a(0), 64'h0); wr(typ_a(2), 64'h0); wr(cnt_a(0), 64'h0);
    wr(CSET, 64'hF);
    wr(SWI, 64'h8000_0007);
    rd(cnt_a(0), v); chk("R3 swinc cnt0", v, 64'h1);
    rd(cnt_a(1), v); chk("R3 non-swinc type", v, 64'h2);
    rd(cnt_a(2), v); chk("R3 swinc cnt2", v, 64'h1);
    rd(cnt_a(3), v); chk("R3 bit not written", v, 64'h0);
    rd(CYC, v);      chk("R3 cycle untouched", v, 64'h0);
  endtask

  task automatic t_both;
    logic [63:0] v;
    wr(cnt_a(0), 64'h5);
    wr_en_i = 1'b1; wr_addr_i = SWI; wr_data_i = 64'h1;
    evt_valid_i = 1'b1; evt_num_i = 16'h0;
    @(negedge clk_i);
    wr_en_i = 1'b0; evt_valid_i = 1'b0;
    rd(cnt_a(0), v); chk("R4 sw plus hw", v, 64'h7);
  endtask

  task automatic t_ovf32;
    logic [63:0] v;
    wr(OCLR, 64'hFFFF_FFFF);
    wr(typ_a(0), 64'h33); wr(cnt_a(0), 64'hFFFF_FFFF);
    ev(16'h33);
    rd(cnt_a(0), v); chk("R5 value after wrap", v, 64'h1_0000_0000);
    rd(OSET, v);     chk("R5 ovs bit0", v, 64'h1);
    rd(cnt_a(1), v); chk("R7 no chain to non-chain type", v, 64'h2);
  endtask

  task automatic t_chain;
    logic [63:0] v;
    wr(OCLR, 64'hFFFF_FFFF);
    wr(typ_a(1), 64'h1E); wr(cnt_a(1), 64'hFFFF_FFFF); wr(cnt_a(0), 64'hFFFF_FFFF);
    ev(16'h33);
    rd(cnt_a(1), v); chk("R7 odd took chain", v, 64'h1_0000_0000);
    rd(OSET, v);     chk("R7 both flags", v, 64'h3);
  endtask

  task automatic t_long;
    logic [63:0] v;
    wr(OCLR, 64'hFFFF_FFFF);
    wr(CTRL, 64'h21);
    wr(typ_a(2), 64'h33); wr(typ_a(3), 64'h1E);
    wr(cnt_a(2), 64'hFFFF_FFFF); wr(cnt_a(3), 64'h0);
    ev(16'h33);
    rd(cnt_a(2), v); chk("R6 32-bit wrap value", v, 64'h1_0000_0000);
    rd(OSET, v);     chk("R6 no 32-bit flag", v, 64'h0);
    wr(cnt_a(2), 64'hFFFF_FFFF_FFFF_FFFF);
    ev(16'h33);
    rd(cnt_a(2), v); chk("R6 64-bit wrap value", v, 64'h0);
    rd(OSET, v);     chk("R6 64-bit flag", v, 64'h4);
    rd(cnt_a(3), v); chk("R8 no chain in long mode", v, 64'h0);
  endtask

  task automatic t_cyc;
    logic [63:0] v;
    wr(CTRL, 64'h1); wr(OCLR, 64'hFFFF_FFFF);
    wr(CYC, 64'hFFFF_FFFF);
    wr(CSET, 64'h8000_0000); wr(CCLR, 64'h8000_0000);
    rd(CYC, v);  chk("R9 cycle wrap value", v, 64'h1_0000_0000);
    rd(OSET, v); chk("R9 cycle flag", v, 64'h8000_0000);
    wr(CYC, 64'h0); wr(CSET, 64'h8000_0000);
    repeat (4) @(negedge clk_i);
    wr(CCLR, 64'h8000_0000);
    rd(CYC, v);  chk("R9 per-clock count", v, 64'h5);
    wr(CTRL, 64'h11); wr(OCLR, 64'hFFFF_FFFF);
    wr(CYC, 64'hFFFF_FFFF);
    wr(CSET, 64'h8000_0000); wr(CCLR, 64'h8000_0000);
    rd(CYC, v);  chk("R9 long value", v, 64'h1_0000_0000);
    rd(OSET, v); chk("R9 long no flag", v, 64'h0);
  endtask

  task automatic t_clear;
    logic [63:0] v;
    wr(CTRL, 64'h7);
    rd(cnt_a(0), v); chk("R10 cnt0 cleared", v, 64'h0);
    rd(cnt_a(1), v); chk("R10 cnt1 cleared", v, 64'h0);
    rd(CYC, v);      chk("R10 cycle cleared", v, 64'h0);
    rd(CTRL, v);     chk("R10 one-shot bits read zero", v, 64'h401);
  endtask

  task automatic t_irq;
    wr(OCLR, 64'hFFFF_FFFF); wr(OSET, 64'h1);
    chk("R11 no int enable", 64'(irq_o), 64'h0);
    wr(ISET, 64'h1); #1;
    chk("R11 raised", 64'(irq_o), 64'h1);
    wr(CTRL, 64'h0); #1;
    chk("R11 global off", 64'(irq_o), 64'h0);
    wr(CTRL, 64'h1); #1;
    chk("R11 global on", 64'(irq_o), 64'h1);
    wr(CCLR, 64'h1); #1;
    chk("R11 counter disabled", 64'(irq_o), 64'h0);
  endtask

  task automatic t_bitmap;
    logic [63:0] v;
    wr(CSET, 64'hFFFF_FFFF); rd(CSET, v); chk("R12 set valid only", v, 64'h8000_000F);
    wr(CCLR, 64'h5);         rd(CCLR, v); chk("R12 clear w1c", v, 64'h8000_000A);
    wr(OSET, 64'hFFFF_FFFF); rd(OSET, v); chk("R12 ovs set valid", v, 64'h8000_000F);
    wr(OCLR, 64'h8000_0000); rd(OSET, v); chk("R12 ovs clear", v, 64'hF);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_gate;
    t_match;
    t_swinc;
    t_both;
    t_ovf32;
    t_chain;
    t_long;
    t_cyc;
    t_clear;
    t_irq;
    t_bitmap;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule